// File: doc/BRIEF.md
# Frame-Synced Serial Sample Transmitter

This block empties a capture buffer of 12-bit samples over a three-wire serial port. The port has a bit clock, a frame-sync strobe and a data line. The block is always the port master, so it generates the bit clock and the frame sync itself. The bit clock is derived from the system clock through a programmable half-period count.

A static port-select input stands in for the interface-select setting. While that input is high, a rising edge on the dump request starts one transfer. Frame sync is raised for exactly one bit period, with the data line held low. On the next bit period the first sample begins, most significant bit first. Samples are pulled from a show-ahead FIFO read interface and sent back to back, with no gap between words. When the FIFO is empty at a word boundary, the port goes quiet and a one-cycle completion strobe is raised.

Top module: `sample_serializer_tx`

## Requirements
- R1: After reset, and whenever no transfer runs, `ser_clk`, `ser_fs`, `ser_dout`, `fifo_rd` and `xfer_done` are all low.
- R2: A transfer starts only on a rising edge of `dump_req`, and only while `port_sel` is 1. A rising edge while `port_sel` is 0 produces no bit clock, no read and no completion strobe.
- R3: Frame sync rises while `ser_clk` is low and stays high for exactly one bit period (2·H system cycles). Exactly one rising edge of `ser_clk` sees it high, and that edge is the first one of the transfer.
- R4: Each word is sent MSB first as 12 bits. The MSB occupies the bit period right after the frame-sync period, and `ser_dout` is low while frame sync is high.
- R5: `ser_dout` changes only in the same cycle as a falling edge of `ser_clk`, so a receiver samples it on the rising edge.
- R6: Words leave in FIFO order with no gap: the MSB of a word directly follows the LSB of the previous one. `fifo_rd` pulses once per word, and only while `fifo_empty` is 0. `fifo_data` is expected to present the head word (show-ahead), and the word is popped at the clock edge where `fifo_rd` is high.
- R7: `ser_clk` has a period of 2·H system cycles, high for H and low for H, where H is `half_per`. A `half_per` of 0 is treated as 1.
- R8: When the FIFO is empty at a word boundary, the transfer ends on that falling bit-clock edge. `ser_fs` and `ser_dout` are low from then on, and `xfer_done` is high for exactly one cycle.
- R9: A rising `dump_req` during a running transfer is ignored. A `dump_req` held high past the end of a transfer does not start a new one.
- R10: A rising `dump_req` with `port_sel` high and the FIFO empty raises `xfer_done` for one cycle, with no frame sync and no bit clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 1 | Serial port chosen as the active output interface |
| half_per | input | HP_W | Bit-clock half period in system cycles (0 acts as 1) |
| dump_req | input | 1 | Transfer request, acted on at its rising edge |
| fifo_empty | input | 1 | Capture FIFO has no word |
| fifo_data | input | WORD_W | Head word of the FIFO (show-ahead) |
| fifo_rd | output | 1 | Pop the head word at this clock edge |
| ser_clk | output | 1 | Serial bit clock |
| ser_fs | output | 1 | Frame-sync strobe |
| ser_dout | output | 1 | Serial data |
| xfer_done | output | 1 | One-cycle transfer-complete strobe |

## Verification
The bench builds the block with its default widths: 12-bit words and an 8-bit half-period field. Half periods are driven from 0 through 5, which makes the clamp of 0 to a 2-cycle bit period reachable, along with odd and even divider lengths. Bursts of one to four words cover the sync-to-first-word handoff, the word-to-word handoff and the end-of-buffer stop. Directed runs cover a deselected port, a request with an empty buffer, a second request mid-transfer and a request held high across the end of a transfer.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SYNC  = 2'd1,
    ST_SHIFT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/ser_bitclk_gen.sv
// Bit-clock divider: toggles every H system cycles while run is high.
module ser_bitclk_gen #(
  parameter int HP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [HP_W-1:0] half_per,
  output logic            sclk,
  output logic            fall_tick
);
  localparam logic [HP_W-1:0] HP_ONE = {{(HP_W-1){1'b0}}, 1'b1};

  logic [HP_W-1:0] cnt_q, cnt_d, hp_eff;
  logic            sclk_q, sclk_d, tick;

  always_comb begin
    hp_eff = (half_per == '0) ? HP_ONE : half_per;
    tick   = run && (cnt_q >= (hp_eff - HP_ONE));
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + HP_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk      = sclk_q;
  assign fall_tick = tick && sclk_q;
endmodule

// File: rtl/ser_word_shifter.sv
// Parallel-load shift register, MSB first, with a registered data bit.
module ser_word_shifter #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              clr,
  input  logic [WORD_W-1:0] din,
  output logic              dout
);
  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic              dout_q, dout_d;

  always_comb begin
    sreg_d = sreg_q;
    dout_d = dout_q;
    if (clr) begin
      sreg_d = '0;
      dout_d = 1'b0;
    end else if (load) begin
      dout_d = din[WORD_W-1];
      sreg_d = {din[WORD_W-2:0], 1'b0};
    end else if (shift) begin
      dout_d = sreg_q[WORD_W-1];
      sreg_d = {sreg_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      dout_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/ser_tx_ctrl.sv
// Transfer sequencer: request edge, sync period, word boundaries, end.
module ser_tx_ctrl
  import ser_tx_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic port_sel,
  input  logic dump_req,
  input  logic fifo_empty,
  input  logic fall_tick,
  output logic run,
  output logic load,
  output logic shift,
  output logic clr,
  output logic fifo_rd,
  output logic fs,
  output logic done
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  tx_state_e        state_q, state_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic             dump_q, fs_q, fs_d, done_q, done_d;
  logic             start, boundary, finish;

  always_comb begin
    start    = (state_q == ST_IDLE) && dump_req && !dump_q && port_sel;
    boundary = fall_tick && ((state_q == ST_SYNC) ||
               ((state_q == ST_SHIFT) && (bit_q == LAST_BIT)));
    load     = boundary && !fifo_empty;
    finish   = boundary && fifo_empty;
    shift    = fall_tick && (state_q == ST_SHIFT) && (bit_q != LAST_BIT);
    clr      = finish;

    state_d = state_q;
    bit_d   = bit_q;
    fs_d    = fs_q;
    done_d  = finish || (start && fifo_empty);

    unique case (state_q)
      ST_IDLE: begin
        if (start && !fifo_empty) begin
          state_d = ST_SYNC;
          fs_d    = 1'b1;
        end
      end
      ST_SYNC: begin
        if (boundary) begin
          fs_d    = 1'b0;
          bit_d   = '0;
          state_d = load ? ST_SHIFT : ST_IDLE;
        end
      end
      ST_SHIFT: begin
        if (load) begin
          bit_d = '0;
        end else if (finish) begin
          state_d = ST_IDLE;
        end else if (shift) begin
          bit_d = bit_q + CNT_ONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      dump_q  <= 1'b0;
      fs_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      dump_q  <= dump_req;
      fs_q    <= fs_d;
      done_q  <= done_d;
    end
  end

  assign run     = (state_q != ST_IDLE);
  assign fifo_rd = load;
  assign fs      = fs_q;
  assign done    = done_q;
endmodule

// File: rtl/sample_serializer_tx.sv
module sample_serializer_tx #(
  parameter int WORD_W = 12,
  parameter int HP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_sel,
  input  logic [HP_W-1:0]   half_per,
  input  logic              dump_req,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              fifo_rd,
  output logic              ser_clk,
  output logic              ser_fs,
  output logic              ser_dout,
  output logic              xfer_done
);
  logic run, fall_tick, load, shift, clr;

  ser_bitclk_gen #(.HP_W(HP_W)) clkgen_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .half_per  (half_per),
    .sclk      (ser_clk),
    .fall_tick (fall_tick)
  );

  ser_tx_ctrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_sel   (port_sel),
    .dump_req   (dump_req),
    .fifo_empty (fifo_empty),
    .fall_tick  (fall_tick),
    .run        (run),
    .load       (load),
    .shift      (shift),
    .clr        (clr),
    .fifo_rd    (fifo_rd),
    .fs         (ser_fs),
    .done       (xfer_done)
  );

  ser_word_shifter #(.WORD_W(WORD_W)) shifter_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .shift (shift),
    .clr   (clr),
    .din   (fifo_data),
    .dout  (ser_dout)
  );
endmodule

// File: rtl/ser_tx_checker.sv
module ser_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic fifo_empty,
  input logic fifo_rd,
  input logic ser_clk,
  input logic ser_fs,
  input logic ser_dout,
  input logic xfer_done
);
  assert_fs_rise_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_fs) |-> !ser_clk);

  assert_fs_drop_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_fs) |-> $fell(ser_clk));

  assert_dout_quiet_in_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_fs |-> !ser_dout);

  assert_dout_moves_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dout) |-> $fell(ser_clk));

  assert_read_not_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  assert_read_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> $fell(ser_clk));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  assert_done_port_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!ser_fs && !ser_dout && !ser_clk));
endmodule

bind sample_serializer_tx ser_tx_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_empty (fifo_empty),
  .fifo_rd    (fifo_rd),
  .ser_clk    (ser_clk),
  .ser_fs     (ser_fs),
  .ser_dout   (ser_dout),
  .xfer_done  (xfer_done)
);

// File: tb/sample_serializer_tx_tb_top.sv
module sample_serializer_tx_tb_top;
  localparam int WORD_W = 12;
  localparam int HP_W   = 8;
  // {half_per, word count, seed}
  localparam int NVEC = 6;
  localparam int VEC [0:NVEC-1][0:2] = '{
    '{1, 1, 3}, '{1, 3, 7}, '{2, 2, 11}, '{3, 4, 0}, '{5, 1, 21}, '{0, 3, 5}
  };

  logic              clk, rst_n, port_sel, dump_req;
  logic [HP_W-1:0]   half_per;
  logic              fifo_empty, fifo_rd, ser_clk, ser_fs, ser_dout, xfer_done;
  logic [WORD_W-1:0] fifo_data;

  int checks = 0;
  int fails  = 0;

  // FIFO model (show-ahead)
  logic [WORD_W-1:0] fifo_mem [0:63];
  int pops = 0;
  int base = 0;
  int fcnt = 0;
  assign fifo_empty = (pops - base) >= fcnt;
  assign fifo_data  = fifo_empty ? '0 : fifo_mem[(pops - base) & 63];
  always @(posedge clk) if (fifo_rd && !fifo_empty) pops <= pops + 1;

  sample_serializer_tx #(.WORD_W(WORD_W), .HP_W(HP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .half_per(half_per),
    .dump_req(dump_req), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_rd(fifo_rd), .ser_clk(ser_clk), .ser_fs(ser_fs),
    .ser_dout(ser_dout), .xfer_done(xfer_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Receiver / monitor, sampled at the falling system-clock edge
  logic mon_clr;
  logic prev_sclk, prev_dout, prev_done;
  int cyc, rises, fs_rises, first_fs, fs_cycles, bit_n, nrx;
  int done_cnt, done_wide, dchg_bad, per_min, per_max, last_rise, synced;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] rx_words [0:63];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mon_clr) begin
      rises = 0; fs_rises = 0; first_fs = 0; fs_cycles = 0; bit_n = 0; nrx = 0;
      done_cnt = 0; done_wide = 0; dchg_bad = 0; per_min = 1000; per_max = 0;
      last_rise = -1; synced = 0; acc = '0;
    end else begin
      if (ser_fs) fs_cycles = fs_cycles + 1;
      if (xfer_done) done_cnt = done_cnt + 1;
      if (xfer_done && prev_done) done_wide = done_wide + 1;
      if ((ser_dout !== prev_dout) && !(prev_sclk && !ser_clk)) dchg_bad = dchg_bad + 1;
      if (ser_clk && !prev_sclk) begin
        if (rises == 0 && ser_fs) first_fs = 1;
        rises = rises + 1;
        if (last_rise >= 0) begin
          if (cyc - last_rise < per_min) per_min = cyc - last_rise;
          if (cyc - last_rise > per_max) per_max = cyc - last_rise;
        end
        last_rise = cyc;
        if (ser_fs) begin
          fs_rises = fs_rises + 1;
          synced = 1;
          bit_n = 0;
        end else if (synced != 0) begin
          acc = {acc[WORD_W-2:0], ser_dout};
          bit_n = bit_n + 1;
          if (bit_n == WORD_W) begin
            rx_words[nrx & 63] = acc;
            nrx = nrx + 1;
            bit_n = 0;
          end
        end
      end
    end
    prev_sclk = ser_clk;
    prev_dout = ser_dout;
    prev_done = xfer_done;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk) mon_clr = 1'b1;
    @(negedge clk) mon_clr = 1'b0;
  endtask

  task automatic load_fifo(input int n, input int seed);
    base = pops;
    for (int k = 0; k < n; k++)
      fifo_mem[k] = WORD_W'(((seed * 733) + (k * 2477)) ^ (k * 5));
    fcnt = n;
  endtask

  task automatic pulse_dump();
    @(negedge clk) dump_req = 1'b1;
    @(negedge clk) dump_req = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done_cnt > 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_xfer(input int hp, input int n);
    int h;
    h = (hp == 0) ? 1 : hp;
    chk(done_cnt == 1 && done_wide == 0, "R8 done pulse", done_cnt, 1);
    chk(fs_rises == 1 && first_fs == 1, "R3 sync on first rise", fs_rises, 1);
    chk(fs_cycles == 2 * h, "R3 sync width", fs_cycles, 2 * h);
    chk(rises == 1 + WORD_W * n, "R4 bit count", rises, 1 + WORD_W * n);
    chk(per_min == 2 * h && per_max == 2 * h, "R7 bit period", per_max, 2 * h);
    chk(dchg_bad == 0, "R5 data edge", dchg_bad, 0);
    chk(nrx == n, "R6 word count", nrx, n);
    for (int k = 0; k < n; k++)
      chk(rx_words[k] == fifo_mem[k], "R4 R6 word value", int'(rx_words[k]), int'(fifo_mem[k]));
    chk(pops - base == n, "R6 pops", pops - base, n);
    chk(!ser_clk && !ser_fs && !ser_dout, "R8 port quiet", {ser_clk, ser_fs, ser_dout}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc = 0; mon_clr = 1'b1; prev_sclk = 0; prev_dout = 0; prev_done = 0;
    rst_n = 1'b0; port_sel = 1'b1; dump_req = 1'b0; half_per = 8'd1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk({ser_clk, ser_fs, ser_dout, fifo_rd, xfer_done} == 5'b0, "R1 reset outputs",
        {ser_clk, ser_fs, ser_dout, fifo_rd, xfer_done}, 0);
    clear_mon();

    // Table-driven transfers
    for (int v = 0; v < NVEC; v++) begin
      half_per = HP_W'(VEC[v][0]);
      load_fifo(VEC[v][1], VEC[v][2]);
      clear_mon();
      pulse_dump();
      wait_done(2000);
      check_xfer(VEC[v][0], VEC[v][1]);
    end

    // R2: deselected port ignores request
    half_per = 8'd2;
    port_sel = 1'b0;
    load_fifo(2, 9);
    clear_mon();
    pulse_dump();
    repeat (60) @(negedge clk);
    chk(rises == 0 && done_cnt == 0, "R2 deselected no clock", rises, 0);
    chk(pops - base == 0, "R2 deselected no read", pops - base, 0);
    port_sel = 1'b1;
    repeat (20) @(negedge clk);
    chk(rises == 0, "R2 select alone no start", rises, 0);
    pulse_dump();
    wait_done(2000);
    check_xfer(2, 2);

    // R9: second request mid-transfer ignored
    load_fifo(3, 13);
    clear_mon();
    pulse_dump();
    repeat (30) @(negedge clk);
    pulse_dump();
    wait_done(2000);
    check_xfer(2, 3);

    // R9: request held high does not retrigger
    load_fifo(1, 17);
    clear_mon();
    @(negedge clk) dump_req = 1'b1;
    wait_done(2000);
    check_xfer(2, 1);
    load_fifo(2, 19);
    clear_mon();
    repeat (60) @(negedge clk);
    chk(rises == 0 && pops - base == 0, "R9 held request no restart", rises, 0);
    @(negedge clk) dump_req = 1'b0;

    // R10: empty buffer request
    fcnt = 0; base = pops;
    clear_mon();
    pulse_dump();
    repeat (20) @(negedge clk);
    chk(done_cnt == 1 && done_wide == 0, "R10 empty done pulse", done_cnt, 1);
    chk(rises == 0 && fs_cycles == 0, "R10 empty no sync", fs_cycles, 0);
    chk({ser_clk, ser_fs, ser_dout, fifo_rd} == 4'b0, "R1 idle outputs",
        {ser_clk, ser_fs, ser_dout, fifo_rd}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule